// File: doc/BRIEF.md
# Receive Descriptor Ring Pointer Registers

This block keeps the two pointers that bound a circular ring of receive descriptors. The consume pointer (head) marks the next descriptor hardware will use. The refill pointer (tail) marks where software will place the next free descriptor. Each pointer counts whole descriptors of 16 bytes, not bytes. Hardware moves head forward one slot per accepted consume request and wraps it to zero after the last slot. Software moves tail forward through a 32-bit register bus when it hands fresh descriptors to hardware.

Each pointer answers at two bus addresses: a primary location and a legacy alias. Head belongs to hardware. Software may load it only while receive is disabled. A head write made while receive is enabled is dropped and raises a sticky error flag. From the two pointers and a ring-size input, the block drives a count of the descriptors hardware may still use and a ring-empty flag.

Top module: `rx_ring_ptr_regs`

## Requirements
- R1: After reset, head and tail are 0, `ring_empty` is 1, `avail_count` is 0 and `head_wr_err` is 0.
- R2: A bus write to tail address 0x2818 or its alias 0x128 loads tail with `bus_wdata[15:0]` at the next clock edge. Bits 31:16 of the write data have no effect.
- R3: While `bus_req` is 1 and `bus_we` is 0, `bus_rdata` returns in the same cycle `{16'h0, head}` at 0x2810 or 0x120 and `{16'h0, tail}` at 0x2818 or 0x128. It returns 0 at any other address.
- R4: A bus write to head address 0x2810 or its alias 0x120 while `rx_enable` is 0 loads head with `bus_wdata[15:0]` at the next clock edge.
- R5: A head write while `rx_enable` is 1 leaves head unchanged and sets `head_wr_err`. That flag stays 1 until reset.
- R6: `ring_empty` is 1 exactly when head equals tail. `avail_count` equals (tail − head) modulo `ring_size`.
- R7: When `hw_consume` is 1, `rx_enable` is 1 and the ring is not empty, `consume_ack` is 1 in the same cycle and head advances by one at the next edge.
- R8: An accepted consume at head = `ring_size` − 1 wraps head to 0.
- R9: A consume request while the ring is empty or `rx_enable` is 0 is refused: `consume_ack` is 0 and head is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_enable | input | 1 | Receive function enabled |
| ring_size | input | 16 | Number of descriptors in the ring |
| hw_consume | input | 1 | Hardware request to use one descriptor |
| consume_ack | output | 1 | Consume request accepted this cycle |
| avail_count | output | 16 | Descriptors hardware may still use |
| ring_empty | output | 1 | Head equals tail |
| head_wr_err | output | 1 | Sticky flag: head written while receive enabled |

## Verification
The bench targets the wrap of head from the last slot to zero. A design that gets it wrong would step head past the ring end or land on slot 1. It checks that a head write made while receive is enabled is dropped. A faulty design would corrupt head, or would raise the error flag and then lose it. It checks that consume requests are refused on an empty ring or while receive is disabled; a design that accepted them would run head past tail. It writes both pointers through their alias addresses with junk in the upper data bits, which catches a missing alias decode or reserved bits leaking into the pointer. It also exercises the modular count when tail sits below head, where plain subtraction gives a huge value.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HEAD = 2'd1,
        SEL_TAIL = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/rxr_addr_decode.sv
module rxr_addr_decode
    import rxr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned N_LOC   = 2,
    parameter logic [N_LOC*ADDR_W-1:0] HEAD_LOCS = {16'h0120, 16'h2810},
    parameter logic [N_LOC*ADDR_W-1:0] TAIL_LOCS = {16'h0128, 16'h2818}
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    logic [N_LOC-1:0] head_hit;
    logic [N_LOC-1:0] tail_hit;

    for (genvar i = 0; i < N_LOC; i++) begin : g_loc
        assign head_hit[i] = (addr == HEAD_LOCS[i*ADDR_W +: ADDR_W]);
        assign tail_hit[i] = (addr == TAIL_LOCS[i*ADDR_W +: ADDR_W]);
    end

    always_comb begin
        if (|head_hit)      sel = SEL_HEAD;
        else if (|tail_hit) sel = SEL_TAIL;
        else                sel = SEL_NONE;
    end

    // R3: an address never selects both registers
    always_comb begin
        a_sel_exclusive_r3: assert (!((|head_hit) && (|tail_hit)));
    end

endmodule

// File: rtl/rxr_ring_math.sv
module rxr_ring_math #(
    parameter int unsigned PTR_W = 16
) (
    input  logic [PTR_W-1:0] head,
    input  logic [PTR_W-1:0] tail,
    input  logic [PTR_W-1:0] ring_size,
    output logic             empty,
    output logic [PTR_W-1:0] avail,
    output logic [PTR_W-1:0] head_next
);

    localparam int unsigned SUM_W = PTR_W + 1;

    logic [SUM_W-1:0] wrapped_span;
    logic             last_slot;

    assign empty        = (head == tail);
    assign wrapped_span = {1'b0, tail} + {1'b0, ring_size} - {1'b0, head};
    assign last_slot    = ({1'b0, head} + 1'b1) == {1'b0, ring_size};

    always_comb begin
        if (tail >= head) avail = tail - head;
        else              avail = wrapped_span[PTR_W-1:0];
    end

    always_comb begin
        if (last_slot) head_next = '0;
        else           head_next = head + 1'b1;
    end

    // R6: empty ring reports no available descriptors
    always_comb begin
        a_empty_zero_r6: assert (!empty || avail == '0);
    end

endmodule

// File: rtl/rx_ring_ptr_regs.sv
module rx_ring_ptr_regs
    import rxr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PTR_W      = 16,
    parameter logic [ADDR_W-1:0] HEAD_MAIN  = 16'h2810,
    parameter logic [ADDR_W-1:0] HEAD_ALIAS = 16'h0120,
    parameter logic [ADDR_W-1:0] TAIL_MAIN  = 16'h2818,
    parameter logic [ADDR_W-1:0] TAIL_ALIAS = 16'h0128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_enable,
    input  logic [PTR_W-1:0]  ring_size,
    input  logic              hw_consume,
    output logic              consume_ack,
    output logic [PTR_W-1:0]  avail_count,
    output logic              ring_empty,
    output logic              head_wr_err
);

    localparam int unsigned PAD_W = DATA_W - PTR_W;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic             err;
    } ring_state_t;

    ring_state_t st_d, st_q;
    reg_sel_e    sel;
    logic [PTR_W-1:0] head_next;
    logic        wr_head;
    logic        wr_tail;
    logic        head_wr_ok;
    logic        head_wr_bad;
    logic        unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PTR_W];

    rxr_addr_decode #(
        .ADDR_W    (ADDR_W),
        .N_LOC     (2),
        .HEAD_LOCS ({HEAD_ALIAS, HEAD_MAIN}),
        .TAIL_LOCS ({TAIL_ALIAS, TAIL_MAIN})
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    rxr_ring_math #(
        .PTR_W (PTR_W)
    ) u_math (
        .head      (st_q.head),
        .tail      (st_q.tail),
        .ring_size (ring_size),
        .empty     (ring_empty),
        .avail     (avail_count),
        .head_next (head_next)
    );

    assign wr_head     = bus_req && bus_we && (sel == SEL_HEAD);
    assign wr_tail     = bus_req && bus_we && (sel == SEL_TAIL);
    assign head_wr_ok  = wr_head && !rx_enable;
    assign head_wr_bad = wr_head && rx_enable;
    assign consume_ack = hw_consume && rx_enable && !ring_empty;

    always_comb begin
        st_d = st_q;
        if (consume_ack) st_d.head = head_next;
        if (head_wr_ok)  st_d.head = bus_wdata[PTR_W-1:0];
        if (head_wr_bad) st_d.err  = 1'b1;
        if (wr_tail)     st_d.tail = bus_wdata[PTR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            case (sel)
                SEL_HEAD: bus_rdata = {{PAD_W{1'b0}}, st_q.head};
                SEL_TAIL: bus_rdata = {{PAD_W{1'b0}}, st_q.tail};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign head_wr_err = st_q.err;

    // R5: a head write during receive leaves head alone
    p_head_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_wr_bad && !consume_ack) |=> $stable(st_q.head));

    // R5: error flag is sticky
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        head_wr_err |=> head_wr_err);

    // R9: no acceptance on an empty ring
    p_no_empty_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ring_empty |-> !consume_ack);

    // R9: refused request leaves head unchanged when software is not loading it
    p_refuse_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_consume && !consume_ack && !head_wr_ok) |=> $stable(st_q.head));

    // R8: wrap at the last slot
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_ack && ({1'b0, st_q.head} + 1'b1 == {1'b0, ring_size})) |=> (st_q.head == '0));

    // R7: accepted consume steps head by one
    p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_ack && ({1'b0, st_q.head} + 1'b1 != {1'b0, ring_size}))
        |=> (st_q.head == $past(st_q.head) + 1'b1));

endmodule

// File: tb/rx_ring_ptr_regs_tb_top.sv
`timescale 1ns/1ps
module rx_ring_ptr_regs_tb_top;

    localparam logic [15:0] A_HEAD  = 16'h2810;
    localparam logic [15:0] A_HEADX = 16'h0120;
    localparam logic [15:0] A_TAIL  = 16'h2818;
    localparam logic [15:0] A_TAILX = 16'h0128;
    localparam int WATCHDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_enable = 1'b0;
    logic [15:0] ring_size = 16'd8;
    logic        hw_consume = 1'b0;
    logic        consume_ack;
    logic [15:0] avail_count;
    logic        ring_empty;
    logic        head_wr_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_head = '0;
    logic [15:0] m_tail = '0;
    logic        m_err  = 1'b0;

    always #2.5 clk = ~clk;

    rx_ring_ptr_regs dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .rx_enable   (rx_enable),
        .ring_size   (ring_size),
        .hw_consume  (hw_consume),
        .consume_ack (consume_ack),
        .avail_count (avail_count),
        .ring_empty  (ring_empty),
        .head_wr_err (head_wr_err)
    );

    function automatic logic [15:0] f_avail(logic [15:0] h, logic [15:0] t, logic [15:0] s);
        if (t >= h) return t - h;
        return 16'(({1'b0, t} + {1'b0, s}) - {1'b0, h});
    endfunction

    function automatic logic [15:0] f_step(logic [15:0] h, logic [15:0] s);
        if (h == s - 16'd1) return 16'd0;
        return h + 16'd1;
    endfunction

    function automatic bit f_is_head(logic [15:0] a);
        return (a == A_HEAD) || (a == A_HEADX);
    endfunction

    function automatic bit f_is_tail(logic [15:0] a);
        return (a == A_TAIL) || (a == A_TAILX);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_req = 1'b0; bus_we = 1'b0;
        if (f_is_tail(a)) m_tail = d[15:0];
        if (f_is_head(a)) begin
            if (rx_enable) m_err = 1'b1;
            else           m_head = d[15:0];
        end
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic consume(input logic en, input string req);
        logic exp_ack;
        @(negedge clk);
        rx_enable = en;
        hw_consume = 1'b1;
        exp_ack = en && (m_head != m_tail);
        #1;
        chk(req, {31'b0, consume_ack}, {31'b0, exp_ack});
        @(posedge clk);
        #1;
        hw_consume = 1'b0;
        if (exp_ack) m_head = f_step(m_head, ring_size);
    endtask

    task automatic state_check(input string tag);
        logic [31:0] d;
        bus_read(A_HEAD, d);  chk({"R3 head read ", tag}, d, {16'h0, m_head});
        bus_read(A_HEADX, d); chk({"R3 head alias read ", tag}, d, {16'h0, m_head});
        bus_read(A_TAIL, d);  chk({"R3 tail read ", tag}, d, {16'h0, m_tail});
        bus_read(A_TAILX, d); chk({"R3 tail alias read ", tag}, d, {16'h0, m_tail});
        chk({"R6 avail ", tag}, {16'h0, avail_count}, {16'h0, f_avail(m_head, m_tail, ring_size)});
        chk({"R6 empty ", tag}, {31'b0, ring_empty}, {31'b0, (m_head == m_tail)});
        chk({"R5 err flag ", tag}, {31'b0, head_wr_err}, {31'b0, m_err});
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h1d5a_7c03));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 avail", {16'h0, avail_count}, 32'h0);
        chk("R1 empty", {31'b0, ring_empty}, 32'h1);
        chk("R1 err", {31'b0, head_wr_err}, 32'h0);
        rst_n = 1'b1;
        state_check("R1 after reset");

        // R2 tail write with junk upper bits
        bus_write(A_TAIL, 32'hABCD_0003);
        state_check("R2 tail main");

        // R7 three accepted consumes, then R9 empty refusal
        consume(1'b1, "R7 ack");
        consume(1'b1, "R7 ack");
        consume(1'b1, "R7 ack");
        state_check("R7 after three");
        consume(1'b1, "R9 empty refuse");
        state_check("R9 empty");

        // R9 disabled refusal with descriptors present
        bus_write(A_TAILX, 32'hFFFF_0005);
        consume(1'b0, "R9 disabled refuse");
        state_check("R9 disabled");

        // R4 head write via alias while disabled; R6 wrapped count
        rx_enable = 1'b0;
        bus_write(A_HEADX, 32'h5A5A_0006);
        bus_write(A_TAILX, 32'h0000_0002);
        chk("R6 wrapped avail", {16'h0, avail_count}, 32'd4);
        state_check("R4 alias head");

        // R8 wrap 6 -> 7 -> 0
        consume(1'b1, "R7 ack");
        consume(1'b1, "R8 ack at last slot");
        bus_read(A_HEAD, d);
        chk("R8 wrap to zero", d, 32'h0);

        // R5 head write while enabled is dropped
        rx_enable = 1'b1;
        bus_write(A_HEAD, 32'h0000_0004);
        state_check("R5 locked head");
        consume(1'b1, "R7 ack");
        state_check("R5 sticky");

        // R3 unmapped address
        bus_read(16'h2814, d);
        chk("R3 unmapped", d, 32'h0);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [15:0] a;
            op = $urandom % 4;
            case (op)
                0: begin
                    a = ($urandom % 2) ? A_TAIL : A_TAILX;
                    bus_write(a, {16'($urandom), 16'($urandom % 8)});
                end
                1: begin
                    @(negedge clk);
                    rx_enable = 1'($urandom % 2);
                    a = ($urandom % 2) ? A_HEAD : A_HEADX;
                    bus_write(a, {16'($urandom), 16'($urandom % 8)});
                end
                2: consume(1'($urandom % 4 != 0), "R7/R9 random consume");
                default: begin
                    bus_read(16'($urandom), d);
                    if (!f_is_head(bus_addr) && !f_is_tail(bus_addr))
                        chk("R3 random unmapped", d, 32'h0);
                end
            endcase
            state_check("R2/R4/R6 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule